// File: doc/BRIEF.md
# Register Target with Load-Gated Retry

This block is the target side of a peripheral's control/status register space on a simple parallel request bus. Each request carries an address space selector (memory, I/O or configuration), an address, byte enables and write data. A memory request whose address falls in the 4 KB window set by the memory base register, or an I/O request that falls in the 64-byte window set by the I/O base register, reaches one shared bank of 32-bit registers. The I/O window is an alias of the first 64 bytes of that bank. Either kind completes in the same cycle it is presented, with no wait states.

Configuration requests reach a small configuration space that holds an identifier, a command word with the two window enables, a status word with a sticky parity-error flag, and the two base registers. Until the boot-time nonvolatile load reports completion on `load_done`, every configuration request is answered with a retry. No address is remembered between tries. After the load completes, every configuration request is honoured.

The block checks even parity on the write data of each write it accepts. The parity bit arrives one cycle after the data. A mismatch sets the status flag, and software clears the flag by writing a one to it. A request that hits no enabled window and is not a configuration request gets no response at all. The initiator must detect the abort on its own.

Top module: `csr_target`

## Requirements
- R1: A memory request (`req_space`=0) with `req_addr[31:12]` equal to the memory base and memory enable (command bit 1) set is acknowledged in the same cycle it is presented, with no retry.
- R2: An I/O request (`req_space`=1) with `req_addr[31:6]` equal to the I/O base and I/O enable (command bit 0) set is acknowledged in the same cycle. Its byte offset `req_addr[5:0]` addresses the same registers as memory offsets 0x00..0x3F. With I/O enable clear, or with an address outside the 64 bytes, the request gets no response.
- R3: A write to the window updates only the bytes whose `req_be` bit is set (bit n covers data bits 8n+7:8n). A later read of the same word returns the merged value. Read data is valid on `rsp_rdata` in the acknowledge cycle.
- R4: Window offsets at or beyond NREGS*4 bytes are acknowledged, read as zero, and leave every implemented register unchanged when written.
- R5: While `load_done` is low, a configuration request (`req_space`=2) gets `rsp_retry` high and `rsp_ack` low, and a retried write changes nothing.
- R6: While `load_done` is high, every configuration request is acknowledged without retry.
- R7: `rsp_ack` and `rsp_retry` are never high together. With no request, with a request that matches nothing, or with `req_space`=3, both are low and `rsp_rdata` is zero. `rsp_rdata` is also zero on write acknowledges.
- R8: For each acknowledged write, `req_par` in the following cycle must make the count of ones over the 32 data bits, the 4 byte enables and the parity bit even. A mismatch sets the parity-error flag, read at bit 15 of configuration dword 1. Correct parity leaves the flag unchanged.
- R9: The parity-error flag resets to 0. A configuration write to dword 1 with `req_be[1]` set and data bit 15 set clears it, and any other write leaves it alone. A new error in the same cycle as the clear leaves the flag set.
- R10: The configuration layout is indexed by `req_addr[7:2]`. Dword 0 reads DEV_ID. Dword 1 holds the flag at bit 15, memory enable at bit 1 and I/O enable at bit 0. Dword 4 holds the memory base (bits 31:12) and dword 5 holds the I/O base (bits 31:6). All other dwords read zero. A new memory base relocates the memory window at once.
- R11: Memory and I/O requests are never retried, whatever the level of `load_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| load_done | input | 1 | High once the boot-time nonvolatile load has finished |
| req_valid | input | 1 | A request is presented this cycle |
| req_space | input | 2 | 0 memory, 1 I/O, 2 configuration, 3 unused |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | 32 | Byte address of the request |
| req_be | input | 4 | Byte enables of the data word |
| req_wdata | input | 32 | Write data |
| req_par | input | 1 | Even parity bit for the write accepted in the previous cycle |
| rsp_ack | output | 1 | Request completed this cycle |
| rsp_retry | output | 1 | Request terminated with retry |
| rsp_rdata | output | 32 | Read data for an acknowledged read, zero otherwise |

## Verification
The bench builds the block with NREGS=32, so the register bank holds 128 bytes. The top half of the bank is then reachable only through the memory window, and the out-of-range region starting at 0x80 is reachable too. The memory base resets to 0x8000_0000, the I/O base to 0x1000, and both enables reset to 1. Register accesses can therefore run while configuration requests are still being retried, before any configuration write has been made. The non-default DEV_ID makes the identifier read distinguishable from an empty register.

// File: rtl/csr_target_pkg.sv
package csr_target_pkg;

  typedef enum logic [1:0] {
    SP_MEM  = 2'd0,
    SP_IO   = 2'd1,
    SP_CFG  = 2'd2,
    SP_NONE = 2'd3
  } space_e;

  localparam int unsigned CFG_IDX_ID     = 0;
  localparam int unsigned CFG_IDX_STATUS = 1;
  localparam int unsigned CFG_IDX_MBASE  = 4;
  localparam int unsigned CFG_IDX_IOBASE = 5;
  localparam int unsigned PERR_BIT       = 15;

  // Parity bit that makes data, enables and parity together even.
  function automatic logic even_par(input logic [31:0] d, input logic [3:0] be);
    return ^{d, be};
  endfunction

  // Merge new bytes into an old word under byte enables.
  function automatic logic [31:0] be_merge(input logic [31:0] old_w,
                                           input logic [31:0] new_w,
                                           input logic [3:0]  be);
    logic [31:0] r;
    for (int b = 0; b < 4; b++) begin
      r[8*b +: 8] = be[b] ? new_w[8*b +: 8] : old_w[8*b +: 8];
    end
    return r;
  endfunction

  // True when the address matches the base on every bit kept by the mask.
  function automatic logic base_match(input logic [31:0] addr,
                                      input logic [31:0] base,
                                      input logic [31:0] mask);
    return ((addr ^ base) & mask) == 32'd0;
  endfunction

endpackage

// File: rtl/csr_addr_decode.sv
module csr_addr_decode
  import csr_target_pkg::*;
#(
  parameter int unsigned MEM_SPAN_LOG2 = 12,
  parameter int unsigned IO_SPAN_LOG2  = 6
) (
  input  logic                     req_valid,
  input  logic [1:0]               req_space,
  input  logic [31:0]              req_addr,
  input  logic [31:0]              mem_base,
  input  logic [31:0]              io_base,
  input  logic                     mem_en,
  input  logic                     io_en,
  input  logic                     load_done,
  output logic                     hit_win,
  output logic                     hit_cfg,
  output logic                     cfg_retry,
  output logic                     acc_ack,
  output logic [MEM_SPAN_LOG2-3:0] win_word,
  output logic [5:0]               cfg_idx
);
  localparam logic [31:0] MEM_MASK = ~((32'd1 << MEM_SPAN_LOG2) - 32'd1);
  localparam logic [31:0] IO_MASK  = ~((32'd1 << IO_SPAN_LOG2) - 32'd1);

  space_e sp;
  logic   hit_mem, hit_io;

  assign sp      = space_e'(req_space);
  assign hit_mem = req_valid && (sp == SP_MEM) && mem_en &&
                   base_match(req_addr, mem_base, MEM_MASK);
  assign hit_io  = req_valid && (sp == SP_IO) && io_en &&
                   base_match(req_addr, io_base, IO_MASK);
  assign hit_win = hit_mem || hit_io;
  assign hit_cfg = req_valid && (sp == SP_CFG);

  // Configuration is gated by the boot load; window accesses never are.
  assign cfg_retry = hit_cfg && !load_done;
  assign acc_ack   = hit_win || (hit_cfg && load_done);

  // The I/O window aliases the bottom of the register bank.
  assign win_word = hit_io ? (MEM_SPAN_LOG2-2)'(req_addr[IO_SPAN_LOG2-1:2])
                           : req_addr[MEM_SPAN_LOG2-1:2];
  assign cfg_idx  = req_addr[7:2];

endmodule

// File: rtl/csr_reg_window.sv
module csr_reg_window
  import csr_target_pkg::*;
#(
  parameter int unsigned NREGS  = 32,
  parameter int unsigned WORD_W = 10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_req,
  input  logic [WORD_W-1:0] word,
  input  logic [31:0]       wdata,
  input  logic [3:0]        be,
  output logic [31:0]       rdata,
  output logic              in_range
);
  localparam int unsigned IDX_W = (NREGS > 1) ? $clog2(NREGS) : 1;

  logic [NREGS-1:0][31:0] words;

  assign in_range = 32'(word) < NREGS;

  for (genvar g = 0; g < NREGS; g++) begin : g_reg
    logic [31:0] q;
    logic        sel;
    assign sel = wr_req && in_range && (word == WORD_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= be_merge(q, wdata, be);
    end
    assign words[g] = q;
  end

  assign rdata = in_range ? words[word[IDX_W-1:0]] : 32'd0;

endmodule

// File: rtl/csr_cfg_space.sv
module csr_cfg_space
  import csr_target_pkg::*;
#(
  parameter logic [31:0] DEV_ID        = 32'h5A5A_0001,
  parameter logic [31:0] MEM_BASE_RST  = 32'h8000_0000,
  parameter logic [31:0] IO_BASE_RST   = 32'h0000_1000,
  parameter logic [1:0]  CMD_RST       = 2'b11,
  parameter int unsigned MEM_SPAN_LOG2 = 12,
  parameter int unsigned IO_SPAN_LOG2  = 6
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [5:0]  idx,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic        perr_evt,
  output logic [31:0] rdata,
  output logic [31:0] mem_base,
  output logic [31:0] io_base,
  output logic        mem_en,
  output logic        io_en,
  output logic        perr_flag,
  output logic        clr_evt
);
  localparam logic [31:0] MEM_MASK = ~((32'd1 << MEM_SPAN_LOG2) - 32'd1);
  localparam logic [31:0] IO_MASK  = ~((32'd1 << IO_SPAN_LOG2) - 32'd1);

  logic [1:0]  cmd_q;
  logic [31:0] mbase_q, iobase_q;
  logic        perr_q;
  logic        wr_stat, wr_mbase, wr_iobase;

  assign wr_stat   = wr_en && (idx == 6'(CFG_IDX_STATUS));
  assign wr_mbase  = wr_en && (idx == 6'(CFG_IDX_MBASE));
  assign wr_iobase = wr_en && (idx == 6'(CFG_IDX_IOBASE));
  assign clr_evt   = wr_stat && be[1] && wdata[PERR_BIT];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q    <= CMD_RST;
      mbase_q  <= MEM_BASE_RST & MEM_MASK;
      iobase_q <= IO_BASE_RST & IO_MASK;
      perr_q   <= 1'b0;
    end else begin
      if (wr_stat && be[0]) cmd_q <= wdata[1:0];
      if (wr_mbase)  mbase_q  <= be_merge(mbase_q, wdata, be) & MEM_MASK;
      if (wr_iobase) iobase_q <= be_merge(iobase_q, wdata, be) & IO_MASK;
      // A fresh error takes priority over a clear in the same cycle.
      if (perr_evt)     perr_q <= 1'b1;
      else if (clr_evt) perr_q <= 1'b0;
    end
  end

  always_comb begin
    unique case (int'(idx))
      CFG_IDX_ID:     rdata = DEV_ID;
      CFG_IDX_STATUS: rdata = {16'h0, perr_q, 13'h0, cmd_q};
      CFG_IDX_MBASE:  rdata = mbase_q;
      CFG_IDX_IOBASE: rdata = iobase_q;
      default:        rdata = 32'd0;
    endcase
  end

  assign mem_base  = mbase_q;
  assign io_base   = iobase_q;
  assign mem_en    = cmd_q[1];
  assign io_en     = cmd_q[0];
  assign perr_flag = perr_q;

endmodule

// File: rtl/csr_parity_check.sv
module csr_parity_check
  import csr_target_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_accept,
  input  logic [31:0] wdata,
  input  logic [3:0]  be,
  input  logic        par_in,
  output logic        perr_evt
);
  logic pend_q, exp_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      exp_q  <= 1'b0;
    end else begin
      pend_q <= wr_accept;
      exp_q  <= even_par(wdata, be);
    end
  end

  // Parity for a write arrives one cycle after its data.
  assign perr_evt = pend_q && (par_in != exp_q);

endmodule

// File: rtl/csr_target.sv
module csr_target
  import csr_target_pkg::*;
#(
  parameter int unsigned NREGS         = 32,
  parameter int unsigned MEM_SPAN_LOG2 = 12,
  parameter int unsigned IO_SPAN_LOG2  = 6,
  parameter logic [31:0] DEV_ID        = 32'h5A5A_0001,
  parameter logic [31:0] MEM_BASE_RST  = 32'h8000_0000,
  parameter logic [31:0] IO_BASE_RST   = 32'h0000_1000,
  parameter logic [1:0]  CMD_RST       = 2'b11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_done,
  input  logic        req_valid,
  input  logic [1:0]  req_space,
  input  logic        req_write,
  input  logic [31:0] req_addr,
  input  logic [3:0]  req_be,
  input  logic [31:0] req_wdata,
  input  logic        req_par,
  output logic        rsp_ack,
  output logic        rsp_retry,
  output logic [31:0] rsp_rdata
);
  localparam int unsigned WORD_W = MEM_SPAN_LOG2 - 2;

  logic              hit_win, hit_cfg, cfg_retry, acc_ack;
  logic [WORD_W-1:0] win_word;
  logic [5:0]        cfg_idx;
  logic [31:0]       mem_base, io_base, win_rdata, cfg_rdata;
  logic              mem_en, io_en, win_in_range;
  logic              perr_evt, perr_flag, clr_evt;
  logic              win_wr, cfg_wr, wr_accept, oor_read;

  csr_addr_decode #(.MEM_SPAN_LOG2(MEM_SPAN_LOG2), .IO_SPAN_LOG2(IO_SPAN_LOG2)) u_dec (
    .req_valid(req_valid), .req_space(req_space), .req_addr(req_addr),
    .mem_base(mem_base), .io_base(io_base), .mem_en(mem_en), .io_en(io_en),
    .load_done(load_done), .hit_win(hit_win), .hit_cfg(hit_cfg),
    .cfg_retry(cfg_retry), .acc_ack(acc_ack), .win_word(win_word), .cfg_idx(cfg_idx)
  );

  assign wr_accept = acc_ack && req_write;
  assign win_wr    = wr_accept && hit_win;
  assign cfg_wr    = wr_accept && hit_cfg;

  csr_reg_window #(.NREGS(NREGS), .WORD_W(WORD_W)) u_win (
    .clk(clk), .rst_n(rst_n), .wr_req(win_wr), .word(win_word),
    .wdata(req_wdata), .be(req_be), .rdata(win_rdata), .in_range(win_in_range)
  );

  csr_cfg_space #(
    .DEV_ID(DEV_ID), .MEM_BASE_RST(MEM_BASE_RST), .IO_BASE_RST(IO_BASE_RST),
    .CMD_RST(CMD_RST), .MEM_SPAN_LOG2(MEM_SPAN_LOG2), .IO_SPAN_LOG2(IO_SPAN_LOG2)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_wr), .idx(cfg_idx), .wdata(req_wdata),
    .be(req_be), .perr_evt(perr_evt), .rdata(cfg_rdata), .mem_base(mem_base),
    .io_base(io_base), .mem_en(mem_en), .io_en(io_en), .perr_flag(perr_flag),
    .clr_evt(clr_evt)
  );

  csr_parity_check u_par (
    .clk(clk), .rst_n(rst_n), .wr_accept(wr_accept), .wdata(req_wdata),
    .be(req_be), .par_in(req_par), .perr_evt(perr_evt)
  );

  // Named event for the checker: a read that lands past the bank.
  assign oor_read = acc_ack && hit_win && !req_write && !win_in_range;

  assign rsp_ack   = acc_ack;
  assign rsp_retry = cfg_retry;
  assign rsp_rdata = (acc_ack && !req_write) ? (hit_cfg ? cfg_rdata : win_rdata) : 32'd0;

endmodule

// File: rtl/csr_target_chk.sv
module csr_target_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        load_done,
  input logic        req_valid,
  input logic [1:0]  req_space,
  input logic        req_write,
  input logic        rsp_ack,
  input logic        rsp_retry,
  input logic [31:0] rsp_rdata,
  input logic        perr_evt,
  input logic        clr_evt,
  input logic        perr_flag,
  input logic        oor_read
);
  AST_CFG_RETRY_EARLY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd2 && !load_done) |-> (rsp_retry && !rsp_ack)); // R5
  AST_CFG_HONOURED: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space == 2'd2 && load_done) |-> (rsp_ack && !rsp_retry)); // R6
  AST_ACK_RETRY_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ack && rsp_retry)); // R7
  AST_IDLE_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |-> (!rsp_ack && !rsp_retry)); // R7
  AST_RDATA_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_ack && !req_write) |-> (rsp_rdata == 32'd0)); // R7
  AST_WIN_NO_RETRY: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_space != 2'd2) |-> !rsp_retry); // R11
  AST_OOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    oor_read |-> (rsp_rdata == 32'd0)); // R4
  AST_PERR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    perr_evt |=> perr_flag); // R8
  AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (perr_flag && !clr_evt) |=> perr_flag); // R9
  AST_FLAG_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_evt && !perr_evt) |=> !perr_flag); // R9
endmodule

bind csr_target csr_target_chk u_chk (
  .clk(clk), .rst_n(rst_n), .load_done(load_done), .req_valid(req_valid),
  .req_space(req_space), .req_write(req_write), .rsp_ack(rsp_ack),
  .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata), .perr_evt(perr_evt),
  .clr_evt(clr_evt), .perr_flag(perr_flag), .oor_read(oor_read)
);

// File: tb/tb_csr_target.sv
module tb_csr_target;
  localparam int CLK_P = 10;
  localparam logic [31:0] ID = 32'hC0DE_7A11;
  localparam logic [31:0] MB = 32'h8000_0000;
  localparam logic [31:0] IB = 32'h0000_1000;

  logic clk = 1'b0, rst_n = 1'b0, load_done = 1'b0;
  logic req_valid = 1'b0, req_write = 1'b0, req_par = 1'b0;
  logic [1:0] req_space = 2'd0;
  logic [31:0] req_addr = '0, req_wdata = '0;
  logic [3:0] req_be = '0;
  logic rsp_ack, rsp_retry;
  logic [31:0] rsp_rdata;

  int checks = 0, failures = 0;
  logic next_par = 1'b0;
  logic [31:0] model [32];

  typedef struct { logic ack; logic retry; logic [31:0] rdata; string tag; } exp_t;
  exp_t sb_q[$];

  always #(CLK_P/2) clk = ~clk;

  csr_target #(.NREGS(32), .DEV_ID(ID), .MEM_BASE_RST(MB), .IO_BASE_RST(IB),
               .CMD_RST(2'b11)) dut (
    .clk(clk), .rst_n(rst_n), .load_done(load_done), .req_valid(req_valid),
    .req_space(req_space), .req_write(req_write), .req_addr(req_addr),
    .req_be(req_be), .req_wdata(req_wdata), .req_par(req_par),
    .rsp_ack(rsp_ack), .rsp_retry(rsp_retry), .rsp_rdata(rsp_rdata));

  function automatic logic good_par(input logic [31:0] d, input logic [3:0] be);
    return ($countones(d) + $countones(be)) % 2 == 1;
  endfunction

  function automatic logic [31:0] merge(input logic [31:0] o, input logic [31:0] n,
                                        input logic [3:0] be);
    logic [31:0] m = '0;
    for (int i = 0; i < 32; i++) m[i] = be[i/8];
    return (o & ~m) | (n & m);
  endfunction

  // Driver: presents one request and pushes its expected response.
  task automatic access(input logic [1:0] sp, input logic wr, input logic [31:0] a,
                        input logic [3:0] be, input logic [31:0] d, input logic bad,
                        input logic e_ack, input logic e_retry, input logic [31:0] e_rd,
                        input string tag);
    exp_t e;
    @(negedge clk);
    req_valid = 1'b1; req_space = sp; req_write = wr; req_addr = a;
    req_be = be; req_wdata = d; req_par = next_par;
    next_par = good_par(d, be) ^ bad;
    e.ack = e_ack; e.retry = e_retry; e.rdata = e_rd; e.tag = tag;
    sb_q.push_back(e);
  endtask

  task automatic idle();
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_par = next_par; next_par = 1'b0;
  endtask

  task automatic win_wr(input logic [1:0] sp, input logic [31:0] a, input int off,
                        input logic [3:0] be, input logic [31:0] d, input logic bad,
                        input string tag);
    access(sp, 1'b1, a, be, d, bad, 1'b1, 1'b0, 32'd0, tag);
    if (off < 128) model[off/4] = merge(model[off/4], d, be);
  endtask

  // Monitor: compares each response away from the clock edge.
  always begin
    exp_t e;
    @(negedge clk);
    #3;
    if (sb_q.size() > 0) begin
      e = sb_q.pop_front();
      checks++;
      if (rsp_ack !== e.ack || rsp_retry !== e.retry || rsp_rdata !== e.rdata) begin
        failures++;
        $display("FAIL %s: actual ack=%0b retry=%0b rdata=%h expected ack=%0b retry=%0b rdata=%h",
                 e.tag, rsp_ack, rsp_retry, rsp_rdata, e.ack, e.retry, e.rdata);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int i = 0; i < 32; i++) model[i] = 32'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk); #3;
    checks++;
    if (rsp_ack !== 1'b0 || rsp_retry !== 1'b0 || rsp_rdata !== 32'd0) begin
      failures++;
      $display("FAIL R7 reset idle: actual ack=%0b retry=%0b rdata=%h expected 0 0 0",
               rsp_ack, rsp_retry, rsp_rdata);
    end
    // Load still running: configuration retried, window served.
    access(2'd2, 1'b0, 32'h0, 4'hF, 32'h0, 1'b0, 1'b0, 1'b1, 32'd0, "R5 cfg read early");
    access(2'd2, 1'b1, 32'h10, 4'hF, 32'h1234_5000, 1'b0, 1'b0, 1'b1, 32'd0, "R5 cfg write early");
    win_wr(2'd0, MB, 0, 4'hF, 32'hDEAD_BEEF, 1'b0, "R1 R11 mem write early");
    access(2'd0, 1'b0, MB, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[0], "R1 R11 mem read");
    access(2'd1, 1'b0, IB, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[0], "R2 io alias read");
    win_wr(2'd1, IB + 32'h3C, 60, 4'b0011, 32'h1111_2222, 1'b0, "R2 io write");
    access(2'd0, 1'b0, MB + 32'h3C, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[15], "R3 merged low bytes");
    win_wr(2'd0, MB + 32'h7C, 124, 4'b1100, 32'hAABB_CCDD, 1'b0, "R3 top-word write");
    access(2'd0, 1'b0, MB + 32'h7C, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[31], "R3 merged high bytes");
    win_wr(2'd0, MB + 32'h80, 128, 4'hF, 32'hFFFF_FFFF, 1'b0, "R4 write past bank");
    access(2'd0, 1'b0, MB + 32'h80, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'd0, "R4 read past bank");
    access(2'd0, 1'b0, MB + 32'hFFC, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'd0, "R4 read window top");
    access(2'd0, 1'b0, MB, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[0], "R4 bank unchanged");
    access(2'd0, 1'b0, 32'h9000_0000, 4'hF, 0, 1'b0, 1'b0, 1'b0, 32'd0, "R7 mem miss");
    access(2'd1, 1'b0, 32'h2000, 4'hF, 0, 1'b0, 1'b0, 1'b0, 32'd0, "R7 io miss");
    access(2'd3, 1'b0, MB, 4'hF, 0, 1'b0, 1'b0, 1'b0, 32'd0, "R7 space 3");
    access(2'd1, 1'b0, IB + 32'h40, 4'hF, 0, 1'b0, 1'b0, 1'b0, 32'd0, "R2 io past 64 bytes");
    idle();
    load_done = 1'b1;
    access(2'd2, 1'b0, 32'h0, 4'hF, 0, 1'b0, 1'b1, 1'b0, ID, "R6 R10 id read");
    access(2'd2, 1'b0, 32'h10, 4'hF, 0, 1'b0, 1'b1, 1'b0, MB, "R5 R10 retried write lost");
    access(2'd2, 1'b0, 32'h14, 4'hF, 0, 1'b0, 1'b1, 1'b0, IB, "R10 io base");
    access(2'd2, 1'b0, 32'h04, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h3, "R8 R9 flag clear after good parity");
    access(2'd2, 1'b0, 32'h08, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'd0, "R10 unused dword");
    // Parity error sets the flag.
    win_wr(2'd0, MB + 32'h4, 4, 4'hF, 32'h0000_0000, 1'b1, "R8 bad parity write");
    idle();
    access(2'd2, 1'b0, 32'h04, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h8003, "R8 flag set");
    access(2'd2, 1'b1, 32'h04, 4'b0011, 32'h0000_0003, 1'b0, 1'b1, 1'b0, 32'd0, "R9 write zero bit");
    idle();
    access(2'd2, 1'b0, 32'h04, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h8003, "R9 flag kept");
    access(2'd2, 1'b1, 32'h04, 4'b0011, 32'h0000_8003, 1'b0, 1'b1, 1'b0, 32'd0, "R9 write one");
    idle();
    access(2'd2, 1'b0, 32'h04, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h3, "R9 flag cleared");
    win_wr(2'd0, MB + 32'h8, 8, 4'hF, 32'h0F0F_0F0F, 1'b1, "R9 bad write before clear");
    access(2'd2, 1'b1, 32'h04, 4'b0011, 32'h0000_8003, 1'b0, 1'b1, 1'b0, 32'd0, "R9 clear with new error");
    idle();
    access(2'd2, 1'b0, 32'h04, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h8003, "R9 set wins");
    access(2'd2, 1'b1, 32'h04, 4'b0011, 32'h0000_8003, 1'b0, 1'b1, 1'b0, 32'd0, "R9 clear again");
    // Relocate and disable windows.
    access(2'd2, 1'b1, 32'h10, 4'hF, 32'h9000_0123, 1'b0, 1'b1, 1'b0, 32'd0, "R10 move mem base");
    access(2'd0, 1'b0, 32'h9000_0000, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[0], "R1 R10 new base hit");
    access(2'd0, 1'b0, MB, 4'hF, 0, 1'b0, 1'b0, 1'b0, 32'd0, "R10 old base miss");
    access(2'd2, 1'b0, 32'h10, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h9000_0000, "R10 base low bits");
    access(2'd2, 1'b1, 32'h04, 4'b0001, 32'h0000_0002, 1'b0, 1'b1, 1'b0, 32'd0, "R2 io disable");
    access(2'd1, 1'b0, IB, 4'hF, 0, 1'b0, 1'b0, 1'b0, 32'd0, "R2 io disabled miss");
    access(2'd2, 1'b0, 32'h04, 4'hF, 0, 1'b0, 1'b1, 1'b0, 32'h2, "R9 R10 status word");
    access(2'd0, 1'b0, 32'h9000_0008, 4'hF, 0, 1'b0, 1'b1, 1'b0, model[2], "R3 bad-parity data kept");
    idle();
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule